// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Shift-Accumulator

This block computes the inner product of L signed input samples with L signed W-bit coefficients for one base unit of a distributed-arithmetic FIR or adaptive filter. No multiplier is used. When a frame starts, the block latches the samples and builds a small table of partial sums from them. The coefficients then arrive one bit position per clock, least significant bit first. Each slice of L bits (one bit from every coefficient) picks a partial sum. That sum is added onto a running total that is halved before each addition. On the last slice, which holds the coefficient sign bits, the picked sum is subtracted, so two's-complement coefficients come out exact.

The table uses a split form. The first L-1 slice bits address 2^(L-1) stored sums. The last slice bit adds the remaining latched sample on its own. This gives half the storage of a full 2^L table, and no offset correction is needed. The table is built by an adder network. A parameter chooses the network style: each entry can reuse a smaller entry plus one sample, or each entry can be summed independently. The result is registered, which supplies one cycle of pipeline delay. A one-cycle done strobe marks each new result. Several instances are meant to feed an adder tree that forms a longer filter.

Top module: `da_shift_acc`

## Requirements
- R1: While reset is asserted, and right after it, `y_o` is 0 and `done_o` and `busy_o` are low.
- R2: A `start_i` accepted while idle latches `smp_i`, where lane i is bits [i*XW +: XW], signed. `busy_o` then stays high for exactly W cycles, beginning in the cycle after the start.
- R3: In the k-th busy cycle (k = 0 first), `slice_i` bit i must carry bit k of coefficient i, so bit positions are consumed from least to most significant.
- R4: The result equals the sum over i of c_i * x_i, where each c_i is a W-bit two's-complement value whose bit W-1 has weight -2^(W-1), and x_i is the latched sample.
- R5: `done_o` is high for exactly one cycle, the cycle after the last busy cycle, and `y_o` takes the new result in that same cycle.
- R6: `y_o` holds its value in every cycle in which `done_o` is low.
- R7: A `start_i` in any busy cycle except the last one has no effect on the result or on the frame timing.
- R8: A `start_i` in the last busy cycle opens the next frame with no idle gap, and both frames produce correct results.
- R9: The running sum never overflows. With every sample at -2^(XW-1) and every coefficient at -2^(W-1), the result is exactly L*2^(XW+W-2).
- R10: Changes on `smp_i` after the start cycle have no effect on the frame's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a frame and latches the samples |
| smp_i | input | L*XW | Packed signed samples, lane i at [i*XW +: XW] |
| slice_i | input | L | Coefficient bit-slice, bit i from coefficient i |
| y_o | output | XW+clog2(L)+W | Signed inner-product result |
| done_o | output | 1 | One-cycle strobe when y_o is updated |
| busy_o | output | 1 | High during the W slice cycles |

## Verification
When `start_i` is sampled at edge E, the slice for bit k is sampled at edge E+1+k. `busy_o` rises after E. `done_o` and the new `y_o` appear after edge E+W and stay valid for the whole cycle that follows. The bench drives inputs 1 ns after each rising edge and samples the outputs at the falling edge. A behavioural model advances on the same rising edges, so each comparison falls in the cycle in which the result is due. In addition, each frame's expected inner product is queued when the frame opens and is compared when the matching `done_o` appears.

// File: rtl/da_sa_pkg.sv
package da_sa_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } da_phase_e;

   // index of the highest set bit of a positive value
   function automatic int top_bit(input int v);
      int r;
      r = 0;
      for (int b = 0; b < 31; b++) begin
         if (((v >> b) & 1) != 0) r = b;
      end
      return r;
   endfunction

endpackage

// File: rtl/da_ptab.sv
module da_ptab #(
   parameter int L     = 4,
   parameter int XW    = 8,
   parameter int PW    = 10,
   parameter int SHARE = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [L*XW-1:0]        smp_i,
   output logic [(2**(L-1))*PW-1:0] tab_o,
   output logic signed [XW-1:0]   tail_o
);
   import da_sa_pkg::*;

   localparam int NT = 2 ** (L - 1);

   logic signed [XW-1:0] xs [L];
   logic [NT*PW-1:0]     comb_flat;
   logic [NT*PW-1:0]     tab_q;
   logic signed [XW-1:0] tail_q;

   for (genvar i = 0; i < L; i++) begin : g_lane
      assign xs[i] = $signed(smp_i[i*XW +: XW]);
   end

   if (SHARE != 0) begin : g_share
      // each entry = smaller entry (top bit cleared) + one sample
      for (genvar j = 0; j < NT; j++) begin : g_e
         logic signed [PW-1:0] val;
         if (j == 0) begin : g_zero
            assign val = '0;
         end else begin : g_add
            localparam int TB = top_bit(j);
            localparam int PJ = j - (1 << TB);
            assign val = g_e[PJ].val + PW'(xs[TB]);
         end
         assign comb_flat[j*PW +: PW] = val;
      end
   end else begin : g_direct
      // each entry summed independently
      always_comb begin
         logic signed [PW-1:0] acc;
         for (int j = 0; j < NT; j++) begin
            acc = '0;
            for (int i = 0; i < L - 1; i++) begin
               if (((j >> i) & 1) != 0) acc = acc + PW'(xs[i]);
            end
            comb_flat[j*PW +: PW] = acc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tab_q  <= '0;
         tail_q <= '0;
      end else if (load) begin
         tab_q  <= comb_flat;
         tail_q <= xs[L-1];
      end
   end

   assign tab_o  = tab_q;
   assign tail_o = tail_q;

endmodule

// File: rtl/da_sel.sv
module da_sel #(
   parameter int L  = 4,
   parameter int XW = 8,
   parameter int PW = 10
) (
   input  logic [(2**(L-1))*PW-1:0] tab_i,
   input  logic signed [XW-1:0]     tail_i,
   input  logic [L-1:0]             slice_i,
   input  logic                     neg_i,
   output logic signed [PW:0]       term_o
);
   localparam int SW = PW + 1;

   logic [L-2:0]         idx;
   logic signed [PW-1:0] ent;
   logic signed [SW-1:0] ent_x;
   logic signed [SW-1:0] tail_x;
   logic signed [SW-1:0] psum;

   assign idx    = slice_i[L-2:0];
   assign ent    = $signed(tab_i[idx*PW +: PW]);
   assign ent_x  = SW'(ent);
   assign tail_x = SW'(tail_i);
   assign psum   = ent_x + (slice_i[L-1] ? tail_x : '0);
   assign term_o = neg_i ? -psum : psum;

endmodule

// File: rtl/da_seq.sv
module da_seq #(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic accept_o,
   output logic busy_o,
   output logic first_o,
   output logic last_o
);
   import da_sa_pkg::*;

   localparam int CW = (W > 1) ? $clog2(W) : 1;

   da_phase_e      phase_q;
   logic [CW-1:0]  cnt_q;

   assign busy_o   = (phase_q == PH_RUN);
   assign first_o  = busy_o && (cnt_q == '0);
   assign last_o   = busy_o && (cnt_q == CW'(W - 1));
   assign accept_o = start_i && (!busy_o || last_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (accept_o) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
      end else if (busy_o) begin
         if (last_o) phase_q <= PH_IDLE;
         else        cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R7
   seq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/da_acc.sv
module da_acc #(
   parameter int SW = 11,
   parameter int W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run_i,
   input  logic                   first_i,
   input  logic                   last_i,
   input  logic signed [SW-1:0]   term_i,
   output logic signed [SW+W-2:0] y_o,
   output logic                   done_o
);
   logic signed [SW-1:0]   s_q;
   logic [W-2:0]           lo_q;
   logic signed [SW-1:0]   t;
   logic signed [SW-1:0]   hs;
   logic signed [SW-1:0]   sn;
   logic [W-2:0]           lo_n;
   logic signed [SW+W-2:0] y_q;
   logic                   done_q;
   logic signed [SW:0]     wide;

   assign t  = first_i ? '0 : s_q;
   assign hs = t >>> 1;
   assign sn = hs + term_i;

   if (W == 2) begin : g_lo1
      assign lo_n = t[0];
   end else begin : g_lon
      assign lo_n = {t[0], lo_q[W-2:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q    <= '0;
         lo_q   <= '0;
         y_q    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= run_i && last_i;
         if (run_i) begin
            s_q  <= sn;
            lo_q <= lo_n;
            if (last_i) y_q <= {sn, lo_n};
         end
      end
   end

   assign y_o    = y_q;
   assign done_o = done_q;

   assign wide = {hs[SW-1], hs} + {term_i[SW-1], term_i};

   // R9
   acc_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (wide[SW] == wide[SW-1]));

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
   parameter int L         = 4,
   parameter int XW        = 8,
   parameter int W         = 8,
   parameter int TAB_SHARE = 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start_i,
   input  logic [L*XW-1:0]                     smp_i,
   input  logic [L-1:0]                        slice_i,
   output logic signed [XW+$clog2(L)+W-1:0]    y_o,
   output logic                                done_o,
   output logic                                busy_o
);
   localparam int GB = $clog2(L);
   localparam int PW = XW + GB;
   localparam int SW = PW + 1;
   localparam int NT = 2 ** (L - 1);
   localparam int RW = PW + W;

   if (L < 2) begin : g_bad_l
      $error("da_shift_acc: L must be at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("da_shift_acc: W must be at least 2");
   end
   if (XW < 2) begin : g_bad_xw
      $error("da_shift_acc: XW must be at least 2");
   end

   logic                 accept;
   logic                 run;
   logic                 first;
   logic                 last;
   logic [NT*PW-1:0]     tab;
   logic signed [XW-1:0] tail;
   logic signed [SW-1:0] term;
   logic signed [RW-1:0] y_int;

   da_seq #(.W(W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (run),
      .first_o  (first),
      .last_o   (last)
   );

   da_ptab #(.L(L), .XW(XW), .PW(PW), .SHARE(TAB_SHARE)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .smp_i  (smp_i),
      .tab_o  (tab),
      .tail_o (tail)
   );

   da_sel #(.L(L), .XW(XW), .PW(PW)) u_sel (
      .tab_i   (tab),
      .tail_i  (tail),
      .slice_i (slice_i),
      .neg_i   (last),
      .term_o  (term)
   );

   da_acc #(.SW(SW), .W(W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .first_i (first),
      .last_i  (last),
      .term_i  (term),
      .y_o     (y_int),
      .done_o  (done_o)
   );

   assign y_o    = y_int;
   assign busy_o = run;

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R5
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(y_o));

endmodule

// File: tb/sim_da_shift_acc.sv
module sim_da_shift_acc;
   localparam int L  = 4;
   localparam int XW = 8;
   localparam int W  = 8;
   localparam int RW = XW + $clog2(L) + W;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start_i = 1'b0;
   logic [L*XW-1:0]      smp_i = '0;
   logic [L-1:0]         slice_i = '0;
   logic signed [RW-1:0] y_o;
   logic                 done_o;
   logic                 busy_o;

   always #5 clk = ~clk;

   da_shift_acc #(.L(L), .XW(XW), .W(W), .TAB_SHARE(1)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .smp_i   (smp_i),
      .slice_i (slice_i),
      .y_o     (y_o),
      .done_o  (done_o),
      .busy_o  (busy_o)
   );

   int  ntests = 0;
   int  nfail  = 0;
   bit  ended  = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int cf[L];
   int xs[L];
   int nc[L];
   int nx[L];
   longint exp_q[$];
   string  tag_q[$];

   function automatic logic [L*XW-1:0] pack(input int v[L]);
      logic [L*XW-1:0] r;
      r = '0;
      for (int i = 0; i < L; i++) r[i*XW +: XW] = v[i][XW-1:0];
      return r;
   endfunction

   function automatic longint dot(input int c[L], input int x[L]);
      longint s;
      s = 0;
      for (int i = 0; i < L; i++) s += longint'(c[i]) * longint'(x[i]);
      return s;
   endfunction

   function automatic logic [L-1:0] slc(input int c[L], input int k);
      logic [L-1:0] r;
      for (int i = 0; i < L; i++) r[i] = ((c[i] >> k) & 1) != 0;
      return r;
   endfunction

   function automatic int rnd8();
      logic [7:0] b;
      b = 8'($urandom());
      return int'($signed(b));
   endfunction

   // behavioural reference model, advanced on each rising edge
   int     m_x[L];
   bit     m_busy;
   int     m_k;
   longint m_acc;
   longint m_y;
   bit     m_done;

   always @(posedge clk) begin
      bit     nd;
      longint p;
      if (!rst_n) begin
         m_busy = 0; m_k = 0; m_acc = 0; m_y = 0; m_done = 0;
      end else begin
         nd = 0;
         if (m_busy) begin
            p = 0;
            for (int i = 0; i < L; i++) if (slice_i[i]) p += m_x[i];
            if (m_k == W - 1) begin
               m_acc -= p * (longint'(1) << m_k);
               m_y = m_acc;
               nd = 1;
            end else begin
               m_acc += p * (longint'(1) << m_k);
            end
         end
         if (start_i && (!m_busy || m_k == W - 1)) begin
            m_busy = 1; m_k = 0; m_acc = 0;
            for (int i = 0; i < L; i++) m_x[i] = int'($signed(smp_i[i*XW +: XW]));
         end else if (m_busy) begin
            if (m_k == W - 1) m_busy = 0;
            else m_k++;
         end
         m_done = nd;
      end
   end

   // comparison away from the active edge
   always @(negedge clk) begin
      longint e;
      string  t;
      if (rst_n && !ended) begin
         chk(busy_o === m_busy, "R2 busy_o vs model", longint'(busy_o), longint'(m_busy));
         chk(done_o === m_done, "R5 done_o vs model", longint'(done_o), longint'(m_done));
         chk(longint'(y_o) == m_y, "R6 y_o vs model", longint'(y_o), m_y);
         if (done_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 done without open frame", 1, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(longint'(y_o) == e, t, longint'(y_o), e);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic open_frame(input string tag);
      tick();
      start_i = 1'b1;
      smp_i   = pack(xs);
      slice_i = '0;
      exp_q.push_back(dot(cf, xs));
      tag_q.push_back(tag);
   endtask

   task automatic run_slices(input bit noise, input bit chain, input string ntag);
      for (int k = 0; k < W; k++) begin
         tick();
         start_i = (noise && k == 2) || (chain && k == W - 1);
         slice_i = slc(cf, k);
         smp_i   = noise ? (L*XW)'({$urandom(), $urandom()}) : pack(xs);
         if (chain && k == W - 1) begin
            smp_i = pack(nx);
            exp_q.push_back(dot(nc, nx));
            tag_q.push_back(ntag);
         end
      end
      if (chain) begin
         cf = nc;
         xs = nx;
      end
   endtask

   task automatic idle(input int n);
      for (int c = 0; c < n; c++) begin
         tick();
         start_i = 1'b0;
         slice_i = L'($urandom());
         smp_i   = (L*XW)'({$urandom(), $urandom()});
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
   endtask

   initial begin
      repeat (3) tick();
      @(negedge clk);
      // R1 reset state
      chk(y_o == 0 && !done_o && !busy_o, "R1 reset state", longint'(y_o), 0);
      tick();
      rst_n = 1'b1;
      idle(2);

      // R3 bit order probe: expected 3-10+448-1408 = -967
      cf = '{1, 2, 64, -128};
      xs = '{3, -5, 7, 11};
      open_frame("R3 LSB-first bit order");
      run_slices(1'b0, 1'b0, "");
      idle(3);

      // R3 single sign bit on coefficient 0
      cf = '{-128, 0, 0, 0};
      xs = '{-7, 100, -100, 55};
      open_frame("R3 sign bit weight");
      run_slices(1'b0, 1'b0, "");
      idle(2);

      // R4 random frames with varied gaps
      for (int f = 0; f < 20; f++) begin
         for (int i = 0; i < L; i++) begin
            cf[i] = rnd8();
            xs[i] = rnd8();
         end
         open_frame("R4 random inner product");
         run_slices(1'b0, 1'b0, "");
         idle(f % 4);
      end

      // R7 and R10: stray start mid-frame, samples toggling
      for (int f = 0; f < 3; f++) begin
         for (int i = 0; i < L; i++) begin
            cf[i] = rnd8();
            xs[i] = rnd8();
         end
         open_frame("R7 R10 stray start and sample noise");
         run_slices(1'b1, 1'b0, "");
         idle(2);
      end

      // R8 back-to-back frames
      for (int i = 0; i < L; i++) begin
         cf[i] = rnd8();
         xs[i] = rnd8();
      end
      open_frame("R8 back-to-back head");
      for (int f = 0; f < 5; f++) begin
         for (int i = 0; i < L; i++) begin
            nc[i] = rnd8();
            nx[i] = rnd8();
         end
         run_slices(1'b0, f < 4, "R8 back-to-back follow");
      end
      idle(3);

      // R9 extremes
      cf = '{-128, -128, -128, -128};
      xs = '{-128, -128, -128, -128};
      open_frame("R9 most negative corner 65536");
      run_slices(1'b0, 1'b0, "");
      idle(1);
      cf = '{-128, -128, -128, -128};
      xs = '{127, 127, 127, 127};
      open_frame("R9 corner -65024");
      run_slices(1'b0, 1'b0, "");
      idle(1);
      cf = '{127, 127, 127, 127};
      xs = '{-128, -128, -128, -128};
      open_frame("R9 corner positive coef");
      run_slices(1'b0, 1'b0, "");
      idle(4);

      chk(exp_q.size() == 0, "R5 all frames completed", exp_q.size(), 0);
      ended = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         ntests++;
         nfail++;
         $display("FAIL watchdog R5 run did not complete actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule